// File: doc/BRIEF.md
# Transceiver Register Setup and Manual Receive-Lock Sequencer

This block runs in the fabric next to a multi-gigabit transceiver. It brings the transceiver up through a register bus. After reset it writes a constant configuration table into the transceiver's register space. It then pulses the receiver reset and steers the receiver to lock by hand. The lock stages are frequency acquisition, then coarse phase alignment, then fine phase alignment. Each stage writes a control word and reads a status register until the stage reports success. If a stage does not succeed within a cycle budget, the block falls back to the receiver reset.

Once the receiver is locked, the block reads a test-output register at a fixed interval and presents the result on its status outputs. The user can request a full re-initialization, a new receiver reset or an early status refresh. Each request is latched and acted on at the next cycle in which no bus transfer is outstanding.

All register traffic uses a minimal APB-style master that performs one single read or single write at a time.

Top module: `xcvr_cfg_seq`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `psel`, `penable`, `init_done`, `rx_rst`, `rx_locked` and `link_ready` are all low.
- R2: After reset the block writes the N_ENTRIES table entries in ascending index order. Entry i is written to address 0x0100 + 4*i with data 0x5A000000 OR (i * 0x00010101).
- R3: Every transfer starts with one cycle of `psel` high and `penable` low. This is followed by `psel` and `penable` both high, holding address, direction and write data steady until `pready` is high. Only one transfer is in flight at a time.
- R4: When the last table write completes, `init_done` goes high. `rx_rst` is then high for exactly RST_HOLD cycles, and there is no bus activity while it is high.
- R5: After each receiver reset, the lock stages run in order. Each stage writes a one-hot code to CTRL_ADDR (0x0040): 1 for frequency, 2 for coarse phase, 4 for fine phase. The stage then reads STAT_ADDR (0x0044) until the matching bit (0, 1 or 2) is set.
- R6: `rx_locked` rises when the fine-phase bit is read as set. Each further read then targets TEST_ADDR (0x0048).
- R7: After every completed read of TEST_ADDR, `status_word` equals the read data and `link_ready` equals its bit 0.
- R8: If a stage's bit is still clear on a read that completes LOCK_TIMEOUT or more cycles after its status polling began, the block returns to the receiver reset. `rx_rst` pulses again and the stages restart at frequency.
- R9: A `rxrst_req` pulse while `init_done` is high clears `rx_locked` and `link_ready`. It restarts the receiver-reset step at the next cycle with no transfer outstanding.
- R10: While locked, successive TEST_ADDR reads are REFRESH_GAP idle cycles apart. A `refresh_req` pulse starts the next read at once instead of waiting out the gap.
- R11: `rxrst_req` and `refresh_req` pulses given while `init_done` is low are discarded. They cause no extra receiver reset and no extra bus write.
- R12: A `reinit_req` pulse clears `init_done`, `rx_locked` and `link_ready`, then rewrites the whole table from entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reinit_req | input | 1 | Pulse: restart from table entry 0 |
| rxrst_req | input | 1 | Pulse: redo receiver reset and lock stages |
| refresh_req | input | 1 | Pulse: read test-output register now |
| psel | output | 1 | Bus select |
| penable | output | 1 | Bus access phase |
| pwrite | output | 1 | Bus direction, 1 = write |
| paddr | output | 16 | Bus address |
| pwdata | output | 32 | Bus write data |
| prdata | input | 32 | Bus read data |
| pready | input | 1 | Bus slave ready |
| init_done | output | 1 | Table fully written |
| rx_rst | output | 1 | Receiver reset strobe |
| rx_locked | output | 1 | All three lock stages passed |
| link_ready | output | 1 | Bit 0 of last test-output read |
| status_word | output | 32 | Last test-output register value |

## Verification
The bench first runs bring-up with every stage bit already set and varying slave wait states. This separates the table order and stage order from timing effects, because any missing, extra or reordered write breaks the write scoreboard. A second pattern clears the fine-phase bit and forces a receiver reset. The expected result is a timeout retry followed by recovery, which separates the timeout path from the user reset path. A changed test-output value is then held back for a long refresh gap and released by a refresh request, which separates the periodic spacing from the early refresh. Last, a re-initialization with reset and refresh requests injected while not yet initialized shows whether those early requests are discarded.

// File: rtl/xcvr_cfg_pkg.sv
package xcvr_cfg_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_INIT,
        S_RXRST,
        S_STG_WR,
        S_STG_POLL,
        S_REFRESH,
        S_HOLDOFF
    } seq_state_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SETUP,
        PH_ACCESS
    } bus_phase_e;

    typedef struct packed {
        logic [15:0] addr;
        logic [31:0] data;
    } cfg_entry_t;

    typedef struct packed {
        logic        wr;
        logic [15:0] addr;
        logic [31:0] wdata;
    } bus_cmd_t;

    localparam logic [15:0] TABLE_BASE = 16'h0100;
    localparam logic [1:0]  LAST_STAGE = 2'd2;

    function automatic cfg_entry_t table_entry(input int unsigned idx);
        cfg_entry_t e;
        e.addr = TABLE_BASE + 16'(idx * 4);
        e.data = 32'h5A00_0000 | 32'(idx * 32'h0001_0101);
        return e;
    endfunction

    function automatic logic [31:0] stage_code(input logic [1:0] stg);
        return 32'(1) << stg;
    endfunction

endpackage

// File: rtl/xcvr_cfg_rom.sv
module xcvr_cfg_rom
    import xcvr_cfg_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic [IW-1:0] idx,
    output cfg_entry_t    entry
);

    cfg_entry_t tbl [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_tbl
        assign tbl[g] = table_entry(g);
    end

    always_comb begin
        entry = '0;
        if (int'(idx) < DEPTH) entry = tbl[idx];
    end

endmodule

// File: rtl/xcvr_apb_master.sv
module xcvr_apb_master
    import xcvr_cfg_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        go,
    input  bus_cmd_t    cmd,
    output logic        done,
    output logic [31:0] rdata,
    output logic        psel,
    output logic        penable,
    output logic        pwrite,
    output logic [15:0] paddr,
    output logic [31:0] pwdata,
    input  logic [31:0] prdata,
    input  logic        pready
);

    bus_phase_e phase;
    bus_cmd_t   held;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            held  <= '0;
        end else begin
            case (phase)
                PH_IDLE: if (go) begin
                    held  <= cmd;
                    phase <= PH_SETUP;
                end
                PH_SETUP:  phase <= PH_ACCESS;
                PH_ACCESS: if (pready) phase <= PH_IDLE;
                default:   phase <= PH_IDLE;
            endcase
        end
    end

    assign psel    = (phase != PH_IDLE);
    assign penable = (phase == PH_ACCESS);
    assign pwrite  = held.wr;
    assign paddr   = held.addr;
    assign pwdata  = held.wdata;
    assign done    = (phase == PH_ACCESS) && pready;
    assign rdata   = prdata;

endmodule

// File: rtl/xcvr_cfg_seq.sv
module xcvr_cfg_seq
    import xcvr_cfg_pkg::*;
#(
    parameter int          N_ENTRIES    = 8,
    parameter int          RST_HOLD     = 6,
    parameter int          LOCK_TIMEOUT = 40,
    parameter int          REFRESH_GAP  = 16,
    parameter logic [15:0] CTRL_ADDR    = 16'h0040,
    parameter logic [15:0] STAT_ADDR    = 16'h0044,
    parameter logic [15:0] TEST_ADDR    = 16'h0048
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reinit_req,
    input  logic        rxrst_req,
    input  logic        refresh_req,
    output logic        psel,
    output logic        penable,
    output logic        pwrite,
    output logic [15:0] paddr,
    output logic [31:0] pwdata,
    input  logic [31:0] prdata,
    input  logic        pready,
    output logic        init_done,
    output logic        rx_rst,
    output logic        rx_locked,
    output logic        link_ready,
    output logic [31:0] status_word
);

    localparam int IDX_W   = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1;
    localparam int CNT_MAX = (RST_HOLD > LOCK_TIMEOUT)
                           ? ((RST_HOLD > REFRESH_GAP) ? RST_HOLD : REFRESH_GAP)
                           : ((LOCK_TIMEOUT > REFRESH_GAP) ? LOCK_TIMEOUT : REFRESH_GAP);
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    seq_state_e       state;
    logic [1:0]       stage;
    logic [IDX_W-1:0] idx;
    logic [CNT_W-1:0] cnt;
    logic             wait_bus;
    logic             pend_reinit, pend_rxrst, pend_refresh;
    logic             done_q, locked_q, ready_q;
    logic [31:0]      status_q;

    cfg_entry_t  rom_entry;
    bus_cmd_t    cmd;
    logic        go, bus_done;
    logic [31:0] bus_rdata;
    logic        needs_bus, take_reinit, take_rxrst, use_refresh;

    xcvr_cfg_rom #(.DEPTH(N_ENTRIES)) u_rom (
        .idx   (idx),
        .entry (rom_entry)
    );

    xcvr_apb_master u_bus (
        .clk     (clk),
        .rst     (rst),
        .go      (go),
        .cmd     (cmd),
        .done    (bus_done),
        .rdata   (bus_rdata),
        .psel    (psel),
        .penable (penable),
        .pwrite  (pwrite),
        .paddr   (paddr),
        .pwdata  (pwdata),
        .prdata  (prdata),
        .pready  (pready)
    );

    // Requests are only taken when no transfer is outstanding.
    always_comb begin
        needs_bus   = (state == S_INIT) || (state == S_STG_WR) ||
                      (state == S_STG_POLL) || (state == S_REFRESH);
        take_reinit = !wait_bus && pend_reinit;
        take_rxrst  = !wait_bus && !pend_reinit && pend_rxrst;
        go          = !wait_bus && !pend_reinit && !pend_rxrst && needs_bus;
        use_refresh = (state == S_HOLDOFF) && !pend_reinit && !pend_rxrst && pend_refresh;
    end

    always_comb begin
        cmd = '0;
        case (state)
            S_INIT:     cmd = '{wr: 1'b1, addr: rom_entry.addr, wdata: rom_entry.data};
            S_STG_WR:   cmd = '{wr: 1'b1, addr: CTRL_ADDR, wdata: stage_code(stage)};
            S_STG_POLL: cmd = '{wr: 1'b0, addr: STAT_ADDR, wdata: 32'h0};
            S_REFRESH:  cmd = '{wr: 1'b0, addr: TEST_ADDR, wdata: 32'h0};
            default:    cmd = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_reinit  <= 1'b0;
            pend_rxrst   <= 1'b0;
            pend_refresh <= 1'b0;
        end else begin
            pend_reinit  <= (pend_reinit && !take_reinit) || reinit_req;
            pend_rxrst   <= done_q && !take_reinit &&
                            ((pend_rxrst && !take_rxrst) || rxrst_req);
            pend_refresh <= locked_q && !take_reinit && !take_rxrst &&
                            ((pend_refresh && !use_refresh) || refresh_req);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= S_IDLE;
            stage    <= '0;
            idx      <= '0;
            cnt      <= '0;
            wait_bus <= 1'b0;
            done_q   <= 1'b0;
            locked_q <= 1'b0;
            ready_q  <= 1'b0;
            status_q <= '0;
        end else if (take_reinit) begin
            state    <= S_IDLE;
            idx      <= '0;
            done_q   <= 1'b0;
            locked_q <= 1'b0;
            ready_q  <= 1'b0;
            status_q <= '0;
        end else if (take_rxrst) begin
            state    <= S_RXRST;
            cnt      <= '0;
            locked_q <= 1'b0;
            ready_q  <= 1'b0;
        end else begin
            if (go)            wait_bus <= 1'b1;
            else if (bus_done) wait_bus <= 1'b0;

            case (state)
                S_IDLE: begin
                    idx   <= '0;
                    state <= S_INIT;
                end
                S_INIT: if (bus_done) begin
                    if (int'(idx) == N_ENTRIES - 1) begin
                        done_q <= 1'b1;
                        cnt    <= '0;
                        state  <= S_RXRST;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                S_RXRST: begin
                    if (cnt == CNT_W'(RST_HOLD - 1)) begin
                        stage <= '0;
                        state <= S_STG_WR;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                S_STG_WR: if (bus_done) begin
                    cnt   <= '0;
                    state <= S_STG_POLL;
                end
                S_STG_POLL: begin
                    if (cnt < CNT_W'(LOCK_TIMEOUT)) cnt <= cnt + 1'b1;
                    if (bus_done) begin
                        if (bus_rdata[stage]) begin
                            if (stage == LAST_STAGE) begin
                                locked_q <= 1'b1;
                                state    <= S_REFRESH;
                            end else begin
                                stage <= stage + 1'b1;
                                state <= S_STG_WR;
                            end
                        end else if (cnt >= CNT_W'(LOCK_TIMEOUT)) begin
                            cnt   <= '0;
                            state <= S_RXRST;
                        end
                    end
                end
                S_REFRESH: if (bus_done) begin
                    status_q <= bus_rdata;
                    ready_q  <= bus_rdata[0];
                    cnt      <= '0;
                    state    <= S_HOLDOFF;
                end
                S_HOLDOFF: begin
                    if (use_refresh || cnt == CNT_W'(REFRESH_GAP - 1)) state <= S_REFRESH;
                    else cnt <= cnt + 1'b1;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    assign init_done   = done_q;
    assign rx_rst      = (state == S_RXRST);
    assign rx_locked   = locked_q;
    assign link_ready  = ready_q;
    assign status_word = status_q;

endmodule

// File: rtl/xcvr_cfg_seq_chk.sv
module xcvr_cfg_seq_chk #(
    parameter int RST_HOLD = 6
) (
    input logic        clk,
    input logic        rst,
    input logic        psel,
    input logic        penable,
    input logic        pready,
    input logic        pwrite,
    input logic [15:0] paddr,
    input logic [31:0] pwdata,
    input logic        init_done,
    input logic        rx_rst,
    input logic        rx_locked,
    input logic        link_ready
);

    logic [15:0] hold_cnt;

    always_ff @(posedge clk) begin
        if (rst)         hold_cnt <= '0;
        else if (rx_rst) hold_cnt <= hold_cnt + 1'b1;
        else             hold_cnt <= '0;
    end

    a_r3_setup_then_access: assert property (@(posedge clk) disable iff (rst)
        (psel && !penable) |=> (psel && penable));

    a_r3_enable_needs_select: assert property (@(posedge clk) disable iff (rst)
        penable |-> psel);

    a_r3_hold_until_ready: assert property (@(posedge clk) disable iff (rst)
        (psel && penable && !pready) |=>
        (psel && penable && $stable(paddr) && $stable(pwrite) && $stable(pwdata)));

    a_r4_reset_after_init: assert property (@(posedge clk) disable iff (rst)
        rx_rst |-> init_done);

    a_r4_quiet_bus_in_reset: assert property (@(posedge clk) disable iff (rst)
        rx_rst |-> !psel);

    a_r4_hold_width: assert property (@(posedge clk) disable iff (rst)
        $fell(rx_rst) |-> (hold_cnt == 16'(RST_HOLD)));

    a_r6_locked_needs_init: assert property (@(posedge clk) disable iff (rst)
        rx_locked |-> (init_done && !rx_rst));

    a_r7_ready_needs_lock: assert property (@(posedge clk) disable iff (rst)
        link_ready |-> rx_locked);

endmodule

bind xcvr_cfg_seq xcvr_cfg_seq_chk #(.RST_HOLD(RST_HOLD)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .psel       (psel),
    .penable    (penable),
    .pready     (pready),
    .pwrite     (pwrite),
    .paddr      (paddr),
    .pwdata     (pwdata),
    .init_done  (init_done),
    .rx_rst     (rx_rst),
    .rx_locked  (rx_locked),
    .link_ready (link_ready)
);

// File: tb/tb_xcvr_cfg_seq.sv
module tb_xcvr_cfg_seq;

    localparam int          N_ENTRIES    = 8;
    localparam int          RST_HOLD     = 6;
    localparam int          LOCK_TIMEOUT = 40;
    localparam int          REFRESH_GAP  = 300;
    localparam logic [15:0] CTRL_A       = 16'h0040;
    localparam logic [15:0] STAT_A       = 16'h0044;
    localparam logic [15:0] TEST_A       = 16'h0048;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reinit_req = 1'b0, rxrst_req = 1'b0, refresh_req = 1'b0;
    logic        psel, penable, pwrite;
    logic [15:0] paddr;
    logic [31:0] pwdata;
    logic [31:0] prdata = '0;
    logic        pready = 1'b0;
    logic        init_done, rx_rst, rx_locked, link_ready;
    logic [31:0] status_word;

    xcvr_cfg_seq #(
        .N_ENTRIES(N_ENTRIES), .RST_HOLD(RST_HOLD), .LOCK_TIMEOUT(LOCK_TIMEOUT),
        .REFRESH_GAP(REFRESH_GAP), .CTRL_ADDR(CTRL_A), .STAT_ADDR(STAT_A), .TEST_ADDR(TEST_A)
    ) dut (
        .clk(clk), .rst(rst), .reinit_req(reinit_req), .rxrst_req(rxrst_req),
        .refresh_req(refresh_req), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
        .init_done(init_done), .rx_rst(rx_rst), .rx_locked(rx_locked),
        .link_ready(link_ready), .status_word(status_word)
    );

    always #5 clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [47:0] act, input logic [47:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    // ---------------- scoreboard of expected writes ----------------
    logic [47:0] exp_q[$];

    task automatic push_table();
        for (int i = 0; i < N_ENTRIES; i++)
            exp_q.push_back({16'h0100 + 16'(4 * i), 32'h5A00_0000 | 32'(i * 32'h0001_0101)});
    endtask

    task automatic push_stages();
        exp_q.push_back({CTRL_A, 32'd1});
        exp_q.push_back({CTRL_A, 32'd2});
        exp_q.push_back({CTRL_A, 32'd4});
    endtask

    // ---------------- slave model and monitor ----------------
    logic        freq_ok = 1'b1, coarse_ok = 1'b1, fine_ok = 1'b1;
    logic [31:0] test_val = 32'h0000_1231;
    int          xfer_no = 0;
    int          wcnt = 0;

    always @(negedge clk) begin
        if (rst) begin
            pready <= 1'b0;
        end else if (psel && !penable) begin
            wcnt   = xfer_no % 3;
            pready <= 1'b0;
        end else if (psel && penable && !pready) begin
            if (wcnt > 0) begin
                wcnt--;
            end else begin
                pready <= 1'b1;
                xfer_no++;
                if (pwrite) begin
                    if (exp_q.size() == 0) begin
                        check(0, "R2/R5", "unexpected write", {paddr, pwdata}, 48'h0);
                    end else begin
                        logic [47:0] e;
                        e = exp_q.pop_front();
                        check({paddr, pwdata} === e, "R2/R5", "write order", {paddr, pwdata}, e);
                    end
                end else begin
                    if (paddr == STAT_A) prdata <= {29'b0, fine_ok, coarse_ok, freq_ok};
                    else if (paddr == TEST_A) prdata <= test_val;
                    else prdata <= 32'h0;
                    check(rx_locked ? (paddr == TEST_A) : (paddr == STAT_A), "R6",
                          "read address", {32'h0, paddr}, {32'h0, rx_locked ? TEST_A : STAT_A});
                end
            end
        end else begin
            pready <= 1'b0;
        end
    end

    // ---------------- receiver reset monitor ----------------
    int  rst_rises = 0;
    int  rst_width = 0;
    logic rx_rst_d = 1'b0;

    always @(negedge clk) begin
        if (!rst) begin
            if (rx_rst && !rx_rst_d) rst_rises++;
            if (rx_rst) rst_width++;
            if (!rx_rst && rx_rst_d) begin
                check(rst_width == RST_HOLD, "R4", "rx_rst width", 48'(rst_width), 48'(RST_HOLD));
                rst_width = 0;
            end
            rx_rst_d = rx_rst;
        end
    end

    // ---------------- watchdog ----------------
    initial begin
        repeat (100000) @(posedge clk);
        check(0, "WDOG", "watchdog expired", 48'h0, 48'h1);
        report();
    end

    task automatic pulse(input int which);
        @(negedge clk);
        case (which)
            0: reinit_req  = 1'b1;
            1: rxrst_req   = 1'b1;
            default: refresh_req = 1'b1;
        endcase
        @(negedge clk);
        reinit_req = 1'b0; rxrst_req = 1'b0; refresh_req = 1'b0;
    endtask

    // ---------------- stimulus ----------------
    initial begin
        int r0;
        push_table();
        push_stages();
        repeat (3) @(negedge clk);
        check({psel, penable, init_done, rx_rst, rx_locked, link_ready} == 6'b0, "R1",
              "outputs in reset", 48'({psel, penable, init_done, rx_rst, rx_locked, link_ready}), 48'h0);
        rst = 1'b0;
        @(negedge clk);
        check({psel, penable, init_done, rx_rst, rx_locked, link_ready} == 6'b0, "R1",
              "outputs after reset", 48'({psel, penable, init_done, rx_rst, rx_locked, link_ready}), 48'h0);

        // bring-up with all stage bits set
        for (int i = 0; i < 2000 && !rx_locked; i++) @(negedge clk);
        check(rx_locked, "R6", "locked after bring-up", 48'(rx_locked), 48'h1);
        check(exp_q.size() == 0, "R2", "table and stage writes consumed", 48'(exp_q.size()), 48'h0);
        check(init_done, "R4", "init_done high", 48'(init_done), 48'h1);
        check(rst_rises == 1, "R4", "one rx_rst pulse", 48'(rst_rises), 48'h1);
        repeat (20) @(negedge clk);
        check(status_word == 32'h0000_1231, "R7", "status word", 48'(status_word), 48'h1231);
        check(link_ready, "R7", "link_ready bit0", 48'(link_ready), 48'h1);

        // refresh spacing and early refresh
        test_val = 32'h0000_0BB0;
        repeat (100) @(negedge clk);
        check(status_word == 32'h0000_1231, "R10", "no read inside gap", 48'(status_word), 48'h1231);
        pulse(2);
        repeat (15) @(negedge clk);
        check(status_word == 32'h0000_0BB0, "R10", "early refresh", 48'(status_word), 48'h0BB0);
        check(!link_ready, "R7", "link_ready follows bit0", 48'(link_ready), 48'h0);

        // user receiver reset, then timeout on the fine stage
        fine_ok = 1'b0;
        push_stages();
        push_stages();
        r0 = rst_rises;
        pulse(1);
        for (int i = 0; i < 50 && !rx_rst; i++) @(negedge clk);
        check(rx_rst && !rx_locked && !link_ready, "R9", "reset request drops lock",
              48'({rx_rst, rx_locked, link_ready}), 48'b100);
        for (int i = 0; i < 1000 && rst_rises < r0 + 2; i++) @(negedge clk);
        check(rst_rises == r0 + 2, "R8", "timeout gives new rx_rst", 48'(rst_rises), 48'(r0 + 2));
        check(!rx_locked, "R8", "not locked after timeout", 48'(rx_locked), 48'h0);
        fine_ok = 1'b1;
        for (int i = 0; i < 1000 && !rx_locked; i++) @(negedge clk);
        check(rx_locked, "R8", "relock after retry", 48'(rx_locked), 48'h1);
        check(exp_q.size() == 0, "R5", "stage writes restarted twice", 48'(exp_q.size()), 48'h0);

        // re-init, early requests discarded
        push_table();
        push_stages();
        r0 = rst_rises;
        pulse(0);
        for (int i = 0; i < 20 && init_done; i++) @(negedge clk);
        check(!init_done && !rx_locked && !link_ready, "R12", "reinit clears flags",
              48'({init_done, rx_locked, link_ready}), 48'h0);
        pulse(1);
        pulse(2);
        for (int i = 0; i < 2000 && !rx_locked; i++) @(negedge clk);
        check(rx_locked, "R12", "locked after reinit", 48'(rx_locked), 48'h1);
        check(rst_rises == r0 + 1, "R11", "early rxrst_req discarded", 48'(rst_rises), 48'(r0 + 1));
        repeat (20) @(negedge clk);
        check(exp_q.size() == 0, "R12", "table rewritten", 48'(exp_q.size()), 48'h0);
        report();
    end

endmodule